// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a set of external interrupt pins and turns chosen pin activity into per-channel interrupt requests. Each channel has its own sense setting: active-low level, active-high level, falling edge, rising edge, or either edge. A detected event is latched in a status bit. Software finds a pending event by reading that status, then writes 1 to the bit to acknowledge it. A per-channel enable mask gates each latched event onto that channel's interrupt output.

The block sits on a plain 32-bit register bus. The bus has an address, a write strobe, write data, and read data that is registered one cycle after the address is presented. The enable mask is changed through two write-only strobe words: one sets the bits written as 1 and the other clears them. This lets independent software agents change different channels without a read-modify-write. Pin inputs are asynchronous. Each one passes through a two-stage synchronizer before the sense logic sees it, and all edge detection runs on the module clock.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous reset, all enables, all status latches and all sense fields are zero, `irq_out` is zero, and every register reads zero.
- R2: A write to offset 0x08 enables each channel whose data bit is 1. Bits written as 0 leave their channels unchanged. Offsets 0x04 and 0x08 both read back the enable mask.
- R3: A write to offset 0x04 disables each channel whose data bit is 1. Bits written as 0 leave their channels unchanged.
- R4: With sense code 0x08 (rising edge), a 0-to-1 pin change applied before clock edge k sets the status bit at edge k+2. The bit stays set after the pin falls, until a write to offset 0x100 with that bit set clears it.
- R5: With sense code 0x04 (falling edge), a 1-to-0 pin change sets the status bit with the same latency as R4.
- R6: With sense code 0x0C (both edges), both rising and falling pin changes set the status bit.
- R7: With sense code 0x02 (high level) or 0x01 (low level), the status bit is set on every cycle the synchronized pin is at its active level. A clear write has no effect while that level persists. Once the level is inactive, a clear write clears the bit.
- R8: A sense field of zero, or any value other than 0x01, 0x02, 0x04, 0x08 or 0x0C, never sets the status bit.
- R9: `irq_out[n]` is the status bit of channel n ANDed with its enable. Offset 0x00 reads the same AND, and disabling a channel leaves its status bit set.
- R10: When a clear write and a new detected event hit the same channel on the same clock edge, the status bit ends up set.
- R11: Channel n's sense field is written and read at offset 0x180 + 4*n in bits [5:0]. Upper data bits are discarded and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered from the address of the previous cycle |
| pin_in | input | NCH | Asynchronous external interrupt pins |
| irq_out | output | NCH | Per-channel interrupt requests |

## Verification
The bench targets the race between a software clear and a fresh edge on the same clock edge. A design that lets the clear win would lose that event and report the status as 0. It also drives a level-sensitive channel with a clear while the level is still active. A design that treats level modes as one-shot latches would drop the bit there, although the pin is still asserted. The edge timing is measured cycle by cycle against the two-stage synchronizer. A design with a missing or extra stage would set `irq_out` one edge early or late. Illegal sense codes, partial set and clear masks, and stray upper bits in a sense field are also applied. They expose a decoder that matches codes too loosely and an enable path that overwrites the mask instead of merging into it.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int SNS_W  = 6;

  localparam logic [ADDR_W-1:0] OFF_REQ   = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_ENCLR = 12'h004;
  localparam logic [ADDR_W-1:0] OFF_ENSET = 12'h008;
  localparam logic [ADDR_W-1:0] OFF_DET   = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 12'h180;

  localparam logic [SNS_W-1:0] SNS_LVL_LO = 6'h01;
  localparam logic [SNS_W-1:0] SNS_LVL_HI = 6'h02;
  localparam logic [SNS_W-1:0] SNS_FALL   = 6'h04;
  localparam logic [SNS_W-1:0] SNS_RISE   = 6'h08;
  localparam logic [SNS_W-1:0] SNS_BOTH   = 6'h0C;
endpackage

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pin,
  input  logic [SNS_W-1:0] mode,
  input  logic             clr,
  output logic             det
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall, hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    case (mode)
      SNS_LVL_LO: hit = ~s2_q;
      SNS_LVL_HI: hit = s2_q;
      SNS_FALL:   hit = fall;
      SNS_RISE:   hit = rise;
      SNS_BOTH:   hit = rise | fall;
      default:    hit = 1'b0;
    endcase
  end

  // a fresh event outranks a clear on the same edge
  always_ff @(posedge clk) begin
    if (rst)      det <= 1'b0;
    else if (hit) det <= 1'b1;
    else if (clr) det <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NCH-1:0]       det,
  output logic [NCH-1:0]       en,
  output logic [NCH*SNS_W-1:0] cfg_flat,
  output logic [NCH-1:0]       clr,
  output logic [DATA_W-1:0]    rdata
);
  logic [DATA_W-1:0] rd_next;
  logic [NCH-1:0]    wmask;

  assign wmask = wdata[NCH-1:0];

  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (we && addr == OFF_ENSET) en <= en | wmask;
    else if (we && addr == OFF_ENCLR) en <= en & ~wmask;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_cfg
    localparam logic [ADDR_W-1:0] CFG_A = OFF_CFG + ADDR_W'(4 * n);
    always_ff @(posedge clk) begin
      if (rst) cfg_flat[n*SNS_W +: SNS_W] <= '0;
      else if (we && addr == CFG_A) cfg_flat[n*SNS_W +: SNS_W] <= wdata[SNS_W-1:0];
    end
  end

  assign clr = (we && addr == OFF_DET) ? wmask : '0;

  always_comb begin
    rd_next = '0;
    if (addr == OFF_REQ)                           rd_next = DATA_W'(det & en);
    else if (addr == OFF_ENCLR || addr == OFF_ENSET) rd_next = DATA_W'(en);
    else if (addr == OFF_DET)                      rd_next = DATA_W'(det);
    else begin
      for (int n = 0; n < NCH; n++) begin
        if (addr == OFF_CFG + ADDR_W'(4 * n))
          rd_next = DATA_W'(cfg_flat[n*SNS_W +: SNS_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [11:0]       bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NCH-1:0]    pin_in,
  output logic [NCH-1:0]    irq_out
);
  logic [NCH-1:0]       en_q;
  logic [NCH-1:0]       det_q;
  logic [NCH-1:0]       clr_w;
  logic [NCH*SNS_W-1:0] cfg_flat;

  ext_irq_regs #(.NCH(NCH)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .wdata    (bus_wdata),
    .det      (det_q),
    .en       (en_q),
    .cfg_flat (cfg_flat),
    .clr      (clr_w),
    .rdata    (bus_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ext_irq_chan chan_i (
      .clk  (clk),
      .rst  (rst),
      .pin  (pin_in[n]),
      .mode (cfg_flat[n*SNS_W +: SNS_W]),
      .clr  (clr_w[n]),
      .det  (det_q[n])
    );
  end

  assign irq_out = det_q & en_q;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk
  import ext_irq_pkg::*;
#(
  parameter int NCH = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NCH-1:0]       en,
  input logic [NCH-1:0]       det,
  input logic [NCH*SNS_W-1:0] cfg_flat
);
  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_ENSET) |=>
      ((en & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0])));

  // R3
  en_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_ENCLR) |=> ((en & $past(bus_wdata[NCH-1:0])) == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [SNS_W-1:0] m;
    logic legal, clr_hit;
    assign m       = cfg_flat[n*SNS_W +: SNS_W];
    assign legal   = (m == SNS_LVL_LO) || (m == SNS_LVL_HI) || (m == SNS_FALL) ||
                     (m == SNS_RISE) || (m == SNS_BOTH);
    assign clr_hit = bus_we && (bus_addr == OFF_DET) && bus_wdata[n];

    // R4
    det_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (det[n] && !clr_hit) |=> det[n]);

    // R8
    no_detect_chk: assert property (@(posedge clk) disable iff (rst)
      (!det[n] && !legal) |=> !det[n]);
  end
endmodule

bind ext_irq_ctrl ext_irq_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .en        (en_q),
  .det       (det_q),
  .cfg_flat  (cfg_flat)
);

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb_top;
  localparam int NCH = 32;
  localparam logic [11:0] A_REQ = 12'h000, A_ECLR = 12'h004, A_ESET = 12'h008,
                          A_DET = 12'h100, A_CFG = 12'h180;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic [11:0] addr;
  logic we;
  logic [31:0] wdata, rdata;
  logic [NCH-1:0] pins, irq;
  int n_chk = 0, n_fail = 0;

  ext_irq_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .pin_in(pins), .irq_out(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [11:0] cfg_a(input int ch);
    return A_CFG + 12'(4 * ch);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq_out", 32'(irq), 32'h0);
    rd(A_REQ, v);  chk("R1 req", v, 32'h0);
    rd(A_ESET, v); chk("R1 enable", v, 32'h0);
    rd(A_DET, v);  chk("R1 detect", v, 32'h0);
    rd(cfg_a(0), v); chk("R1 cfg0", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_ESET, 32'h0000_00F1);
    wr(A_ESET, 32'h0000_0100);
    rd(A_ESET, v); chk("R2 set merges", v, 32'h0000_01F1);
    rd(A_ECLR, v); chk("R2 readback at clear word", v, 32'h0000_01F1);
    wr(A_ECLR, 32'h0000_0130);
    rd(A_ESET, v); chk("R3 partial clear", v, 32'h0000_00C1);
    wr(A_ECLR, 32'hFFFF_FFFF);
    rd(A_ESET, v); chk("R3 clear all", v, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    wr(cfg_a(0), 32'h08);
    wr(A_ESET, 32'h1);
    pins[0] = 1'b1;
    wait_n(2); chk("R4 latency not yet", 32'(irq[0]), 32'h0);
    wait_n(1); chk("R4 latency set", 32'(irq[0]), 32'h1);
    pins[0] = 1'b0;
    wait_n(4);
    rd(A_DET, v); chk("R4 latched after fall", 32'(v[0]), 32'h1);
    rd(A_REQ, v); chk("R9 request read", 32'(v[0]), 32'h1);
    wr(A_ECLR, 32'h1);
    chk("R9 irq gated off", 32'(irq[0]), 32'h0);
    rd(A_DET, v); chk("R9 status kept when disabled", 32'(v[0]), 32'h1);
    wr(A_DET, 32'h1);
    rd(A_DET, v); chk("R4 cleared", 32'(v[0]), 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    pins[1] = 1'b1;
    wait_n(3);
    wr(cfg_a(1), 32'h04);
    wait_n(3);
    rd(A_DET, v); chk("R5 no event on steady high", 32'(v[1]), 32'h0);
    pins[1] = 1'b0;
    wait_n(3);
    rd(A_DET, v); chk("R5 falling detected", 32'(v[1]), 32'h1);
  endtask

  task automatic t_both();
    logic [31:0] v;
    wr(cfg_a(4), 32'h0C);
    pins[4] = 1'b1;
    wait_n(3);
    rd(A_DET, v); chk("R6 rising", 32'(v[4]), 32'h1);
    wr(A_DET, 32'h10);
    rd(A_DET, v); chk("R6 cleared", 32'(v[4]), 32'h0);
    pins[4] = 1'b0;
    wait_n(3);
    rd(A_DET, v); chk("R6 falling", 32'(v[4]), 32'h1);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(cfg_a(2), 32'h02);
    pins[2] = 1'b1;
    wait_n(3);
    wr(A_DET, 32'h4);
    rd(A_DET, v); chk("R7 high level sticks", 32'(v[2]), 32'h1);
    pins[2] = 1'b0;
    wait_n(3);
    wr(A_DET, 32'h4);
    rd(A_DET, v); chk("R7 high level clears", 32'(v[2]), 32'h0);
    wr(cfg_a(3), 32'h01);
    wait_n(1);
    wr(A_DET, 32'h8);
    rd(A_DET, v); chk("R7 low level sticks", 32'(v[3]), 32'h1);
    pins[3] = 1'b1;
    wait_n(3);
    wr(A_DET, 32'h8);
    rd(A_DET, v); chk("R7 low level clears", 32'(v[3]), 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    wr(cfg_a(5), 32'h03);
    wr(cfg_a(8), 32'h18);
    pins[5] = 1'b1; pins[6] = 1'b1; pins[8] = 1'b1;
    wait_n(4);
    pins[5] = 1'b0; pins[6] = 1'b0; pins[8] = 1'b0;
    wait_n(4);
    rd(A_DET, v);
    chk("R8 illegal and zero codes", v & 32'h160, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(cfg_a(7), 32'h08);
    pins[7] = 1'b1;
    wait_n(2);
    wr(A_DET, 32'h80);
    rd(A_DET, v); chk("R10 event beats clear", 32'(v[7]), 32'h1);
    wr(A_DET, 32'h80);
    rd(A_DET, v); chk("R10 later clear works", 32'(v[7]), 32'h0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(cfg_a(9), 32'hFFFF_FFC8);
    rd(cfg_a(9), v);  chk("R11 upper bits dropped", v, 32'h08);
    rd(cfg_a(5), v);  chk("R11 readback ch5", v, 32'h03);
    wr(cfg_a(31), 32'h0C);
    rd(cfg_a(31), v); chk("R11 last channel", v, 32'h0C);
    rd(cfg_a(30), v); chk("R11 neighbour untouched", v, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_rise();
    t_fall();
    t_both();
    t_level();
    t_invalid();
    t_collide();
    t_cfg();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule